// File: doc/BRIEF.md
# Gated Multi-Mode Down-Counter Channel

This block is one 16-bit presettable down-counter channel for a programmable interval timer. It runs on the system clock `clk` and counts on each falling edge of a slower counter clock `ctr_clk_i`, which it samples on the rising edge of `clk`. A register front end, not part of this block, hands it one-cycle pulses: a mode write, a "first byte written" hold, and a "count complete" write carrying the full 16-bit value. The live count is always visible on `count_o` for reads.

Five behaviours are supported: interrupt on terminal count, retriggerable one-shot, rate generator, software-triggered strobe and hardware-triggered strobe. Each has its own output waveform, its own use of the gate (level enable or edge trigger) and its own rule for when a newly written count takes effect. Counting is either plain 16-bit binary or four BCD decades. The square-wave mode codes are accepted but leave the channel idle.

Top module: `tmr_chan`

## Requirements
- R1: While `rst_n` is low at a `clk` edge, `out_o` is high, `count_o` is zero and the channel is idle until a mode is written.
- R2: A `cfg_we_i` pulse with `cfg_mode_i` = 000 drives `out_o` low on the next cycle; any other code drives it high. A mode write stops counting and drops pending loads and latched gate edges; `count_o` keeps its value.
- R3: In mode 000, `out_o` rises at the counting step where the count goes from 1 to 0 and stays high until the next mode or count write; the count keeps decrementing past zero, and a low `gate_i` at a step suspends the decrement.
- R4: In mode 000, a `cnt_hold_i` pulse halts counting; a `cnt_we_i` pulse drives `out_o` low and its value enters the count at the next counter-clock falling edge, after which counting resumes.
- R5: With `cfg_bcd_i` = 0 each counting step subtracts one modulo 65536, so a loaded 0 behaves as 65536 (0 steps to FFFF hex).
- R6: With `cfg_bcd_i` = 1 the count is four BCD digits (bits 3:0 lowest decade) and each step subtracts one decimally, 0000 stepping to 9999.
- R7: In mode 001, a `gate_i` rising edge (sampled on `clk`, held until a step uses it) makes the next step load the full count and drive `out_o` low; `out_o` goes high at the step reaching 0, and any later rising edge restarts the full count.
- R8: In mode 001, a count written while the pulse is running leaves that pulse unchanged and is used from the next trigger.
- R9: In mode 010, the first written count loads at the next step; `out_o` is low for the one step in which the count is 1 and the count reloads at the following step, giving a period of N steps; a write while running only changes the value used at the next reload.
- R10: In mode 010, a low `gate_i` forces `out_o` high at the next `clk` edge and freezes the count; a `gate_i` rising edge makes the next step reload the full count.
- R11: In mode 100, `out_o` is high after the mode write; a written count (also one written mid-count) loads at the next step; the count decrements only while `gate_i` is high, and `out_o` is low for exactly one step at the 1-to-0 step, once per load.
- R12: In mode 101, a `gate_i` rising edge makes the next step load the full count; `out_o` is low for one step when the count reaches 0; a new rising edge restarts the full count, and the gate level does not stop counting.
- R13: Code 110 behaves as mode 010; codes 011 and 111 leave the channel idle with `out_o` high and the count frozen.
- R14: `count_o` changes only at a `clk` edge where `ctr_clk_i` was high at the previous edge and is low now; a rising edge of `ctr_clk_i` alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ctr_clk_i | input | 1 | Counter clock level; a falling edge is one counting step |
| gate_i | input | 1 | Gate level, used as enable or trigger depending on mode |
| cfg_we_i | input | 1 | One-cycle pulse: new mode and number format |
| cfg_mode_i | input | 3 | Mode code written with `cfg_we_i` |
| cfg_bcd_i | input | 1 | 1 selects four-decade BCD counting, 0 binary |
| cnt_hold_i | input | 1 | One-cycle pulse: first part of a new count has been written |
| cnt_we_i | input | 1 | One-cycle pulse: new count complete |
| cnt_val_i | input | 16 | Count value presented with `cnt_we_i` |
| count_o | output | 16 | Live count for reads |
| out_o | output | 1 | Channel output waveform |

## Verification
Each mode is driven with a short count so that the terminal step, the wrap past zero and the reload can be watched one step at a time, separating a design that pulses once from one that pulses on every wrap. Counts are rewritten mid-run in every mode that defines a rule for it, which tells apart "applies now", "applies at the next step" and "applies at the next period or trigger". Gate pulses are placed both while idle and mid-count to separate level-enable behaviour from edge-trigger behaviour, and loads of zero in binary and BCD distinguish the two borrow chains.

// File: rtl/tmr_pkg.sv
// Shared types for the timer channel.
// Assumes the front end presents a raw 3-bit mode code; aliasing is done here.
package tmr_pkg;

    typedef enum logic [2:0] {
        TM_TCINT    = 3'd0,   // output rises at terminal count
        TM_ONESHOT  = 3'd1,   // retriggerable one-shot
        TM_RATE     = 3'd2,   // divide-by-N pulse train
        TM_SQWAVE   = 3'd3,   // square-wave codes: held idle here
        TM_SWSTROBE = 3'd4,   // strobe started by a count write
        TM_HWSTROBE = 3'd5    // strobe started by a gate edge
    } tmr_mode_e;

    // Map a raw mode code onto the behaviour it selects (bit 2 ignored for x1x).
    function automatic tmr_mode_e decode_mode(input logic [2:0] code);
        case (code)
            3'b000:         return TM_TCINT;
            3'b001:         return TM_ONESHOT;
            3'b010, 3'b110: return TM_RATE;
            3'b100:         return TM_SWSTROBE;
            3'b101:         return TM_HWSTROBE;
            default:        return TM_SQWAVE;
        endcase
    endfunction

endpackage

// File: rtl/tmr_edge_det.sv
// Single-edge detector on a level sampled by clk.
// EDGE_FALL picks falling (1) or rising (0) detection; RST_LVL is the level
// assumed before reset release so no edge is reported out of reset.
module tmr_edge_det #(
    parameter bit   EDGE_FALL = 1'b0,
    parameter logic RST_LVL   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic edge_o
);

    logic prev_q;

    // Remember the level seen at the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_LVL;
        else        prev_q <= sig_i;
    end

    generate
        if (EDGE_FALL) begin : g_fall
            assign edge_o = prev_q & ~sig_i;
        end else begin : g_rise
            assign edge_o = sig_i & ~prev_q;
        end
    endgenerate

endmodule

// File: rtl/tmr_decr.sv
// Combinational decrement-by-one in binary or in packed BCD.
// Assumes CNT_W is a multiple of 4; the BCD result is only meaningful for
// inputs whose nibbles are all 0..9. Zero wraps to all-ones / all-nines.
module tmr_decr #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] val_i,
    input  logic             bcd_i,
    output logic [CNT_W-1:0] dec_o
);

    localparam int DIGITS = CNT_W / 4;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [DIGITS-1:0] borrow;
    logic [CNT_W-1:0]  bcd_dec;

    assign borrow[0] = 1'b1;

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_digit
            logic [3:0] dig;
            assign dig = val_i[4*g +: 4];
            // A digit borrowing from zero becomes nine, otherwise drops by one.
            assign bcd_dec[4*g +: 4] = !borrow[g] ? dig :
                                       (dig == 4'd0) ? 4'd9 : dig - 4'd1;
            if (g < DIGITS - 1) begin : g_chain
                assign borrow[g+1] = borrow[g] & (dig == 4'd0);
            end
        end
    endgenerate

    assign dec_o = bcd_i ? bcd_dec : val_i - ONE;

endmodule

// File: rtl/tmr_chan.sv
// One presettable down-counter channel with gate and output.
// Counts on falling edges of ctr_clk_i (sampled on clk); the gate is sampled
// on clk and a rising edge is kept until a counting step uses it.
// Assumes cfg_we_i, cnt_hold_i and cnt_we_i are single-cycle pulses from a
// register front end; a mode write has priority over everything else.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctr_clk_i,
    input  logic             gate_i,
    input  logic             cfg_we_i,
    input  logic [2:0]       cfg_mode_i,
    input  logic             cfg_bcd_i,
    input  logic             cnt_hold_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] cnt_val_i,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o
);

    localparam int DIGITS = CNT_W / 4;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);

    tmr_mode_e        mode_q;
    logic             bcd_q;
    logic             out_q;
    logic             run_q;      // counting has started
    logic             pend_q;     // written count waits for the next step
    logic             trig_q;     // gate rising edge not yet used
    logic             armed_q;    // terminal count still to be signalled
    logic             have_val_q; // a count has been written since the mode
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt_dec;
    logic             step;
    logic             gate_rise;
    logic             trig_now;
    logic             is_strobe;

    tmr_edge_det #(.EDGE_FALL(1'b1), .RST_LVL(1'b0)) u_ctr_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (ctr_clk_i),
        .edge_o (step)
    );

    tmr_edge_det #(.EDGE_FALL(1'b0), .RST_LVL(1'b1)) u_gate_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (gate_i),
        .edge_o (gate_rise)
    );

    tmr_decr #(.CNT_W(CNT_W)) u_decr (
        .val_i (cnt_q),
        .bcd_i (bcd_q),
        .dec_o (cnt_dec)
    );

    assign trig_now  = trig_q | gate_rise;
    assign is_strobe = (mode_q == TM_SWSTROBE) || (mode_q == TM_HWSTROBE);

    // Channel state: mode writes, counting steps, gate effects and count writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= TM_SQWAVE;
            bcd_q      <= 1'b0;
            out_q      <= 1'b1;
            run_q      <= 1'b0;
            pend_q     <= 1'b0;
            trig_q     <= 1'b0;
            armed_q    <= 1'b0;
            have_val_q <= 1'b0;
            cnt_q      <= '0;
            reload_q   <= '0;
        end else if (cfg_we_i) begin
            mode_q     <= decode_mode(cfg_mode_i);
            bcd_q      <= cfg_bcd_i;
            out_q      <= (decode_mode(cfg_mode_i) != TM_TCINT);
            run_q      <= 1'b0;
            pend_q     <= 1'b0;
            trig_q     <= 1'b0;
            armed_q    <= 1'b0;
            have_val_q <= 1'b0;
        end else begin
            trig_q <= trig_now;
            if (step) begin
                trig_q <= 1'b0;
                unique case (mode_q)
                    TM_TCINT, TM_SWSTROBE: begin
                        if (is_strobe && !out_q) out_q <= 1'b1;
                        if (pend_q) begin
                            cnt_q   <= reload_q;
                            pend_q  <= 1'b0;
                            run_q   <= 1'b1;
                            armed_q <= 1'b1;
                        end else if (run_q && gate_i) begin
                            cnt_q <= cnt_dec;
                            if (armed_q && cnt_q == CNT_ONE) begin
                                armed_q <= 1'b0;
                                out_q   <= (mode_q == TM_TCINT);
                            end
                        end
                    end
                    TM_ONESHOT, TM_HWSTROBE: begin
                        if (mode_q == TM_HWSTROBE && !out_q) out_q <= 1'b1;
                        if (trig_now && have_val_q) begin
                            cnt_q   <= reload_q;
                            run_q   <= 1'b1;
                            armed_q <= 1'b1;
                            out_q   <= (mode_q == TM_HWSTROBE);
                        end else if (run_q) begin
                            cnt_q <= cnt_dec;
                            if (armed_q && cnt_q == CNT_ONE) begin
                                armed_q <= 1'b0;
                                out_q   <= (mode_q == TM_ONESHOT);
                            end
                        end
                    end
                    TM_RATE: begin
                        if (gate_i) begin
                            if ((pend_q || trig_now) && have_val_q) begin
                                cnt_q  <= reload_q;
                                pend_q <= 1'b0;
                                run_q  <= 1'b1;
                                out_q  <= 1'b1;
                            end else if (run_q) begin
                                if (cnt_q == CNT_ONE) begin
                                    cnt_q <= reload_q;
                                    out_q <= 1'b1;
                                end else begin
                                    cnt_q <= cnt_dec;
                                    if (cnt_q == CNT_TWO) out_q <= 1'b0;
                                end
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (mode_q == TM_RATE && !gate_i) out_q <= 1'b1;
            if (cnt_hold_i && mode_q == TM_TCINT) run_q <= 1'b0;
            if (cnt_we_i) begin
                reload_q   <= cnt_val_i;
                have_val_q <= 1'b1;
                case (mode_q)
                    TM_TCINT: begin
                        pend_q <= 1'b1;
                        run_q  <= 1'b0;
                        out_q  <= 1'b0;
                    end
                    TM_SWSTROBE: pend_q <= 1'b1;
                    TM_RATE:     if (!run_q) pend_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign count_o = cnt_q;
    assign out_o   = out_q;

    // True when every nibble of v is a decimal digit.
    function automatic logic digits_ok(input logic [CNT_W-1:0] v);
        for (int i = 0; i < DIGITS; i++) begin
            if (v[4*i +: 4] > 4'd9) return 1'b0;
        end
        return 1'b1;
    endfunction

    p_mode0_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i && cfg_mode_i == 3'b000 |=> !out_o);

    p_mode_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i && cfg_mode_i != 3'b000 |=> out_o);

    p_tc_stays_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == TM_TCINT && out_o && !cfg_we_i && !cnt_we_i |=> out_o);

    p_bcd_digits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_q && mode_q == TM_TCINT && step && run_q && !pend_q && gate_i &&
        !cfg_we_i && !cnt_we_i && digits_ok(cnt_q) |=> digits_ok(count_o));

    p_gate_forces_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == TM_RATE && !gate_i && !cfg_we_i |=> out_o);

    p_strobe_one_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        is_strobe && !out_o && step && !cfg_we_i |=> out_o);

    p_square_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q == TM_SQWAVE && !cfg_we_i |=> out_o && $stable(count_o));

    p_count_on_fall_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count_o));

endmodule

// File: tb/sim_tmr_chan.sv
// Scoreboard bench: driver tasks queue the state expected after the next
// clk edge; the monitor pops and compares a quarter period after that edge.
module sim_tmr_chan;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctr_clk_i = 1'b0;
    logic        gate_i = 1'b1;
    logic        cfg_we_i = 1'b0;
    logic [2:0]  cfg_mode_i = 3'b000;
    logic        cfg_bcd_i = 1'b0;
    logic        cnt_hold_i = 1'b0;
    logic        cnt_we_i = 1'b0;
    logic [15:0] cnt_val_i = 16'h0000;
    logic [15:0] count_o;
    logic        out_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    string       q_req[$];
    logic        q_out[$];
    bit          q_chk_cnt[$];
    logic [15:0] q_cnt[$];

    tmr_chan u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctr_clk_i  (ctr_clk_i),
        .gate_i     (gate_i),
        .cfg_we_i   (cfg_we_i),
        .cfg_mode_i (cfg_mode_i),
        .cfg_bcd_i  (cfg_bcd_i),
        .cnt_hold_i (cnt_hold_i),
        .cnt_we_i   (cnt_we_i),
        .cnt_val_i  (cnt_val_i),
        .count_o    (count_o),
        .out_o      (out_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Move to the next falling clk edge and end any one-cycle pulse.
    task automatic nxt();
        @(negedge clk);
        cfg_we_i   = 1'b0;
        cnt_we_i   = 1'b0;
        cnt_hold_i = 1'b0;
    endtask

    task automatic set_mode(input logic [2:0] code, input logic bcd);
        nxt();
        cfg_we_i = 1'b1; cfg_mode_i = code; cfg_bcd_i = bcd;
    endtask

    task automatic load(input logic [15:0] v);
        nxt();
        cnt_we_i = 1'b1; cnt_val_i = v;
    endtask

    task automatic set_gate(input logic v);
        nxt();
        gate_i = v;
    endtask

    // Full counter-clock cycle; the step lands on the edge after return.
    task automatic pulse_ctr();
        nxt(); ctr_clk_i = 1'b1;
        nxt(); ctr_clk_i = 1'b0;
    endtask

    task automatic expect_st(input string req, input logic eo,
                             input bit cc, input logic [15:0] ec);
        q_req.push_back(req); q_out.push_back(eo);
        q_chk_cnt.push_back(cc); q_cnt.push_back(ec);
    endtask

    task automatic chk(input string req, input logic eo, input logic [15:0] ec);
        expect_st(req, eo, 1'b1, ec);
    endtask

    task automatic chk_out(input string req, input logic eo);
        expect_st(req, eo, 1'b0, 16'h0000);
    endtask

    task automatic step_chk(input string req, input logic eo, input logic [15:0] ec);
        pulse_ctr();
        chk(req, eo, ec);
    endtask

    // Monitor: compare queued expectations just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            while (q_req.size() > 0) begin
                string       r;
                logic        eo;
                bit          cc;
                logic [15:0] ec;
                r = q_req.pop_front(); eo = q_out.pop_front();
                cc = q_chk_cnt.pop_front(); ec = q_cnt.pop_front();
                n_checks++;
                if (out_o !== eo || (cc && count_o !== ec)) begin
                    n_fail++;
                    $display("FAIL %s: out=%b count=%h expected out=%b count=%h%s",
                             r, out_o, count_o, eo, ec, cc ? "" : " (count not checked)");
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog (all requirements): run active, expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        nxt(); nxt();
        chk("R1", 1'b1, 16'h0000);
        nxt(); rst_n = 1'b1;
        nxt();
        chk("R1", 1'b1, 16'h0000);

        // Mode 000, binary
        set_mode(3'b000, 1'b0);   chk("R2", 1'b0, 16'h0000);
        load(16'd3);              chk("R4", 1'b0, 16'h0000);
        nxt(); ctr_clk_i = 1'b1;  chk("R14", 1'b0, 16'h0000);
        nxt(); ctr_clk_i = 1'b0;  chk("R4", 1'b0, 16'h0003);
        step_chk("R5", 1'b0, 16'h0002);
        step_chk("R3", 1'b0, 16'h0001);
        step_chk("R3", 1'b1, 16'h0000);
        step_chk("R3", 1'b1, 16'hFFFF);
        set_gate(1'b0);
        step_chk("R3", 1'b1, 16'hFFFF);
        set_gate(1'b1);
        nxt(); cnt_hold_i = 1'b1;
        step_chk("R4", 1'b1, 16'hFFFF);
        load(16'd5);              chk("R4", 1'b0, 16'hFFFF);
        step_chk("R4", 1'b0, 16'h0005);
        step_chk("R4", 1'b0, 16'h0004);
        load(16'd0);
        step_chk("R5", 1'b0, 16'h0000);
        step_chk("R5", 1'b0, 16'hFFFF);

        // Mode 000, BCD
        set_mode(3'b000, 1'b1);
        load(16'h0010);
        step_chk("R6", 1'b0, 16'h0010);
        step_chk("R6", 1'b0, 16'h0009);
        load(16'h0000);
        step_chk("R6", 1'b0, 16'h0000);
        step_chk("R6", 1'b0, 16'h9999);
        step_chk("R6", 1'b0, 16'h9998);

        // Mode 001 one-shot
        set_mode(3'b001, 1'b0);   chk("R2", 1'b1, 16'h9998);
        load(16'd3);
        step_chk("R7", 1'b1, 16'h9998);
        set_gate(1'b0); set_gate(1'b1);
        step_chk("R7", 1'b0, 16'h0003);
        step_chk("R7", 1'b0, 16'h0002);
        load(16'd7);              chk("R8", 1'b0, 16'h0002);
        step_chk("R8", 1'b0, 16'h0001);
        step_chk("R7", 1'b1, 16'h0000);
        set_gate(1'b0); set_gate(1'b1);
        step_chk("R8", 1'b0, 16'h0007);
        step_chk("R7", 1'b0, 16'h0006);
        set_gate(1'b0); set_gate(1'b1);
        step_chk("R7", 1'b0, 16'h0007);

        // Mode 010 rate generator
        set_mode(3'b010, 1'b0);   chk("R2", 1'b1, 16'h0007);
        load(16'd3);
        step_chk("R9", 1'b1, 16'h0003);
        step_chk("R9", 1'b1, 16'h0002);
        step_chk("R9", 1'b0, 16'h0001);
        step_chk("R9", 1'b1, 16'h0003);
        load(16'd4);              chk("R9", 1'b1, 16'h0003);
        step_chk("R9", 1'b1, 16'h0002);
        step_chk("R9", 1'b0, 16'h0001);
        step_chk("R9", 1'b1, 16'h0004);
        step_chk("R9", 1'b1, 16'h0003);
        step_chk("R9", 1'b1, 16'h0002);
        step_chk("R9", 1'b0, 16'h0001);
        set_gate(1'b0);           chk("R10", 1'b1, 16'h0001);
        step_chk("R10", 1'b1, 16'h0001);
        set_gate(1'b1);           chk_out("R10", 1'b1);
        step_chk("R10", 1'b1, 16'h0004);
        step_chk("R10", 1'b1, 16'h0003);

        // Alias and idle codes
        set_mode(3'b110, 1'b0);   chk("R13", 1'b1, 16'h0003);
        load(16'd2);
        step_chk("R13", 1'b1, 16'h0002);
        step_chk("R13", 1'b0, 16'h0001);
        step_chk("R13", 1'b1, 16'h0002);
        set_mode(3'b111, 1'b0);   chk("R13", 1'b1, 16'h0002);
        load(16'd5);
        step_chk("R13", 1'b1, 16'h0002);
        set_mode(3'b011, 1'b0);
        step_chk("R13", 1'b1, 16'h0002);

        // Mode 100 software strobe
        set_mode(3'b100, 1'b0);   chk("R11", 1'b1, 16'h0002);
        load(16'd2);
        step_chk("R11", 1'b1, 16'h0002);
        step_chk("R11", 1'b1, 16'h0001);
        step_chk("R11", 1'b0, 16'h0000);
        step_chk("R11", 1'b1, 16'hFFFF);
        step_chk("R11", 1'b1, 16'hFFFE);
        set_gate(1'b0);
        step_chk("R11", 1'b1, 16'hFFFE);
        set_gate(1'b1);
        load(16'd9);
        step_chk("R11", 1'b1, 16'h0009);

        // Mode 101 hardware strobe
        set_mode(3'b101, 1'b0);   chk("R2", 1'b1, 16'h0009);
        load(16'd3);
        step_chk("R12", 1'b1, 16'h0009);
        set_gate(1'b0); set_gate(1'b1);
        step_chk("R12", 1'b1, 16'h0003);
        step_chk("R12", 1'b1, 16'h0002);
        set_gate(1'b0); set_gate(1'b1);
        step_chk("R12", 1'b1, 16'h0003);
        set_gate(1'b0);
        step_chk("R12", 1'b1, 16'h0002);
        step_chk("R12", 1'b1, 16'h0001);
        step_chk("R12", 1'b0, 16'h0000);
        step_chk("R12", 1'b1, 16'hFFFF);

        nxt(); nxt(); nxt();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule